// File: doc/BRIEF.md
# USB Endpoint DMA Channel Sequencer

This block is the control state machine of a single DMA channel that moves data for one USB device endpoint. Software programs it through control writes that carry three bits: a channel enable, a link enable that lets the channel fetch its next descriptor, and a close enable that ends a buffer early on a packet event. Together, the enable and link bits form four commands: halt, run one buffer and stop, skip to the next descriptor at once, and run one buffer and then chain to the next. A down-counter stands in for the remaining buffer length.

The endpoint signals a transfer request when it can accept or supply data ("endpoint free" for IN, "endpoint full" for OUT). The block answers with a transfer strobe per serviced request cycle, runs a request/acknowledge handshake to fetch descriptors, reports channel-enabled and channel-active status, and pulses an end-of-buffer event. A disable issued mid-transfer takes effect only after the data FIFO has drained. In the high-speed isochronous case, the received PID class decides whether the buffer closes.

Top module: `usb_dma_chan_seq`

## Requirements
- R1: After a synchronous reset, sts_en, sts_active, xfer_strobe, desc_req and eob are all 0.
- R2: A control write while the channel is idle stores enable, link and close, and sts_en shows the written enable on the next cycle. The length is taken only if sts_en and sts_active were both 0 when the write was sampled. Otherwise the old length is kept.
- R3: With enable 1 and a nonzero length, a request starts the buffer. Each running cycle with ep_req high gives one xfer_strobe on the next cycle and uses up one unit of length. When the length runs out, eob pulses, sts_en clears, and with link 0 sts_active falls to 0.
- R4: With link 1 when a buffer completes, desc_req is raised in the same cycle as eob.
- R5: With enable 0 and link 1, an idle request skips the loaded descriptor: desc_req rises with no xfer_strobe and no eob.
- R6: With enable 0 and link 0, requests have no effect: no xfer_strobe, no desc_req, sts_active stays 0.
- R7: A control write with enable 0 during a buffer stops new transfers. sts_en and sts_active stay 1 until fifo_empty is sampled high, then both clear on the next cycle, with no eob.
- R8: On a normal endpoint (ep_hs_iso 0), with close enabled, pkt_end with pkt_short ends the buffer early (eob, sts_en clears). With close disabled, the short packet is ignored.
- R9: On a high-speed isochronous endpoint (ep_hs_iso 1), with close enabled, pkt_end with pid_mdata 0 ends the buffer. With pid_mdata 1 it does not, and pkt_short is ignored.
- R10: desc_req stays high until desc_ack is sampled. At that edge, enable, link, close and length are loaded from desc_en, desc_link, desc_close and desc_len, and the channel returns to idle. A loaded enable of 0 leaves it waiting for software.
- R11: With enable 1 and length 0, a request ends the buffer at once: one eob, no xfer_strobe.
- R12: eob is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en | input | 1 | Written channel enable |
| ctl_link | input | 1 | Written link (load next descriptor) enable |
| ctl_close | input | 1 | Written buffer-close enable |
| ctl_len | input | LEN_W | Written buffer length |
| ep_req | input | 1 | Endpoint transfer request (free for IN, full for OUT) |
| ep_hs_iso | input | 1 | Endpoint is high-speed isochronous |
| pkt_end | input | 1 | End of received packet |
| pkt_short | input | 1 | Received packet was short |
| pid_mdata | input | 1 | Received PID class is MDATA |
| fifo_empty | input | 1 | Channel data FIFO is empty |
| desc_req | output | 1 | Descriptor fetch request |
| desc_ack | input | 1 | Descriptor fetch acknowledge, fields valid |
| desc_en | input | 1 | Fetched enable |
| desc_link | input | 1 | Fetched link enable |
| desc_close | input | 1 | Fetched close enable |
| desc_len | input | LEN_W | Fetched buffer length |
| xfer_strobe | output | 1 | One data transfer performed |
| sts_en | output | 1 | Channel enabled status |
| sts_active | output | 1 | Channel active status |
| eob | output | 1 | One-cycle end-of-buffer event |

## Verification
The bench builds the block with LEN_W = 4 and HS_ISO_CLOSE = 1. The 4-bit length lets full buffers finish within a few cycles, so random runs often reach counter exhaustion, zero-length buffers and chained descriptor fetches. With HS_ISO_CLOSE = 1, the PID-based isochronous close is present, so the random mix of packet events exercises both close rules against the bench's cycle model.

// File: rtl/usb_dma_seq_pkg.sv
package usb_dma_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_FETCH = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic en;
    logic link;
    logic close;
  } chan_cfg_t;

endpackage

// File: rtl/usb_dma_close_det.sv
module usb_dma_close_det #(
  parameter bit HS_ISO_CLOSE = 1'b1
) (
  input  logic close_en,
  input  logic hs_iso,
  input  logic pkt_end,
  input  logic pkt_short,
  input  logic pid_mdata,
  output logic close_hit
);

  generate
    if (HS_ISO_CLOSE) begin : g_pid_close
      // isochronous: any PID class other than MDATA ends the buffer
      assign close_hit = close_en & pkt_end & (hs_iso ? ~pid_mdata : pkt_short);
    end else begin : g_short_only
      assign close_hit = close_en & pkt_end & ~hs_iso & pkt_short;
    end
  endgenerate

endmodule

// File: rtl/usb_dma_len_ctr.sv
module usb_dma_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  input  logic             dec,
  output logic             is_zero,
  output logic             is_last
);

  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (dec && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign is_zero = (cnt_q == '0);
  assign is_last = (cnt_q == ONE);

endmodule

// File: rtl/usb_dma_desc_port.sv
module usb_dma_desc_port (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ack,
  output logic req,
  output logic taken
);

  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else if (start) begin
      req_q <= 1'b1;
    end else if (req_q && ack) begin
      req_q <= 1'b0;
    end
  end

  assign req   = req_q;
  assign taken = req_q & ack;

endmodule

// File: rtl/usb_dma_chan_seq.sv
module usb_dma_chan_seq
  import usb_dma_seq_pkg::*;
#(
  parameter int LEN_W        = 16,
  parameter bit HS_ISO_CLOSE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_en,
  input  logic             ctl_link,
  input  logic             ctl_close,
  input  logic [LEN_W-1:0] ctl_len,
  input  logic             ep_req,
  input  logic             ep_hs_iso,
  input  logic             pkt_end,
  input  logic             pkt_short,
  input  logic             pid_mdata,
  input  logic             fifo_empty,
  output logic             desc_req,
  input  logic             desc_ack,
  input  logic             desc_en,
  input  logic             desc_link,
  input  logic             desc_close,
  input  logic [LEN_W-1:0] desc_len,
  output logic             xfer_strobe,
  output logic             sts_en,
  output logic             sts_active,
  output logic             eob
);

  seq_state_t       st_q, st_nx;
  chan_cfg_t        cfg_q, cfg_nx;
  logic             act_q, xfer_q, eob_q;
  logic             xfer_nx, eob_nx;
  logic             len_ld, len_dec;
  logic [LEN_W-1:0] len_val;
  logic             len_zero, len_last;
  logic             close_hit, desc_taken, fetch_start, done;

  usb_dma_close_det #(.HS_ISO_CLOSE(HS_ISO_CLOSE)) u_close (
    .close_en (cfg_q.close),
    .hs_iso   (ep_hs_iso),
    .pkt_end  (pkt_end),
    .pkt_short(pkt_short),
    .pid_mdata(pid_mdata),
    .close_hit(close_hit)
  );

  usb_dma_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk     (clk),
    .rst     (rst),
    .load    (len_ld),
    .load_val(len_val),
    .dec     (len_dec),
    .is_zero (len_zero),
    .is_last (len_last)
  );

  usb_dma_desc_port u_desc (
    .clk  (clk),
    .rst  (rst),
    .start(fetch_start),
    .ack  (desc_ack),
    .req  (desc_req),
    .taken(desc_taken)
  );

  always_comb begin
    st_nx   = st_q;
    cfg_nx  = cfg_q;
    len_ld  = 1'b0;
    len_val = ctl_len;
    len_dec = 1'b0;
    xfer_nx = 1'b0;
    eob_nx  = 1'b0;
    done    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (ctl_wr) begin
          cfg_nx.en    = ctl_en;
          cfg_nx.link  = ctl_link;
          cfg_nx.close = ctl_close;
          // length only while the channel is frozen
          len_ld = ~cfg_q.en & ~act_q;
        end else if (ep_req) begin
          if (cfg_q.en) begin
            if (len_zero) done = 1'b1;
            else          st_nx = ST_RUN;
          end else if (cfg_q.link) begin
            st_nx = ST_FETCH;
          end
        end
      end
      ST_RUN: begin
        if (ctl_wr) begin
          cfg_nx.link  = ctl_link;
          cfg_nx.close = ctl_close;
        end
        if (ctl_wr && !ctl_en) begin
          st_nx = ST_DRAIN;
        end else begin
          if (ep_req) begin
            len_dec = 1'b1;
            xfer_nx = 1'b1;
            if (len_last) done = 1'b1;
          end
          if (close_hit) done = 1'b1;
        end
      end
      ST_DRAIN: begin
        if (ctl_wr) begin
          cfg_nx.link  = ctl_link;
          cfg_nx.close = ctl_close;
        end
        if (fifo_empty) begin
          cfg_nx.en = 1'b0;
          st_nx     = ST_IDLE;
        end
      end
      ST_FETCH: begin
        if (desc_taken) begin
          cfg_nx.en    = desc_en;
          cfg_nx.link  = desc_link;
          cfg_nx.close = desc_close;
          len_ld       = 1'b1;
          len_val      = desc_len;
          st_nx        = ST_IDLE;
        end
      end
      default: st_nx = ST_IDLE;
    endcase
    if (done) begin
      eob_nx    = 1'b1;
      cfg_nx.en = 1'b0;
      st_nx     = cfg_nx.link ? ST_FETCH : ST_IDLE;
    end
  end

  assign fetch_start = (st_nx == ST_FETCH) && (st_q != ST_FETCH);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      act_q  <= 1'b0;
      xfer_q <= 1'b0;
      eob_q  <= 1'b0;
    end else begin
      st_q   <= st_nx;
      cfg_q  <= cfg_nx;
      act_q  <= (st_nx != ST_IDLE);
      xfer_q <= xfer_nx;
      eob_q  <= eob_nx;
    end
  end

  assign xfer_strobe = xfer_q;
  assign sts_en      = cfg_q.en;
  assign sts_active  = act_q;
  assign eob         = eob_q;

endmodule

// File: rtl/usb_dma_seq_chk.sv
module usb_dma_seq_chk (
  input logic clk,
  input logic rst,
  input logic sts_en,
  input logic sts_active,
  input logic xfer_strobe,
  input logic eob,
  input logic desc_req,
  input logic desc_ack,
  input logic fifo_empty
);

  // R3
  xfer_from_active_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_strobe |-> $past(sts_active));

  // R3
  eob_drops_en_chk: assert property (@(posedge clk) disable iff (rst)
    eob |-> !sts_en);

  // R12
  eob_single_chk: assert property (@(posedge clk) disable iff (rst)
    eob |=> !eob);

  // R10
  desc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_req && !desc_ack) |=> desc_req);

  // R5
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_req && $past(desc_req)) |-> (!xfer_strobe && !eob));

  // R7
  drain_wait_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sts_en) && !eob && $past(sts_active)) |-> $past(fifo_empty));

endmodule

bind usb_dma_chan_seq usb_dma_seq_chk u_seq_chk (
  .clk        (clk),
  .rst        (rst),
  .sts_en     (sts_en),
  .sts_active (sts_active),
  .xfer_strobe(xfer_strobe),
  .eob        (eob),
  .desc_req   (desc_req),
  .desc_ack   (desc_ack),
  .fifo_empty (fifo_empty)
);

// File: tb/usb_dma_chan_seq_test.sv
module usb_dma_chan_seq_test;

  localparam int LW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr = 0, ctl_en = 0, ctl_link = 0, ctl_close = 0;
  logic [LW-1:0] ctl_len = '0;
  logic ep_req = 0, ep_hs_iso = 0, pkt_end = 0, pkt_short = 0, pid_mdata = 0;
  logic fifo_empty = 1;
  logic desc_ack = 0, desc_en = 0, desc_link = 0, desc_close = 0;
  logic [LW-1:0] desc_len = '0;
  logic desc_req, xfer_strobe, sts_en, sts_active, eob;

  int n_chk = 0, n_fail = 0, cycles = 0;
  int n_xfer = 0, n_eob = 0, n_dreq = 0;
  bit done_flag = 0;

  // bench model of the channel
  int m_st = 0;  // 0 idle 1 run 2 drain 3 fetch
  bit m_en, m_link, m_close, m_act, m_xfer, m_eob;
  int m_cnt;

  always #4 clk = ~clk;

  usb_dma_chan_seq #(.LEN_W(LW), .HS_ISO_CLOSE(1'b1)) uut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_en(ctl_en), .ctl_link(ctl_link),
    .ctl_close(ctl_close), .ctl_len(ctl_len), .ep_req(ep_req), .ep_hs_iso(ep_hs_iso),
    .pkt_end(pkt_end), .pkt_short(pkt_short), .pid_mdata(pid_mdata),
    .fifo_empty(fifo_empty), .desc_req(desc_req), .desc_ack(desc_ack),
    .desc_en(desc_en), .desc_link(desc_link), .desc_close(desc_close),
    .desc_len(desc_len), .xfer_strobe(xfer_strobe), .sts_en(sts_en),
    .sts_active(sts_active), .eob(eob)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit close_rule();
    if (!m_close || !pkt_end) return 0;
    return ep_hs_iso ? !pid_mdata : pkt_short;
  endfunction

  task automatic model_step();
    bit fin = 0;
    bit old_en = m_en, old_act = m_act;
    m_xfer = 0; m_eob = 0;
    if (rst) begin
      m_st = 0; m_en = 0; m_link = 0; m_close = 0; m_act = 0; m_cnt = 0;
      return;
    end
    case (m_st)
      0: if (ctl_wr) begin
           m_en = ctl_en; m_link = ctl_link; m_close = ctl_close;
           if (!old_en && !old_act) m_cnt = ctl_len;
         end else if (ep_req) begin
           if (m_en) begin if (m_cnt == 0) fin = 1; else m_st = 1; end
           else if (m_link) m_st = 3;
         end
      1: begin
           bit hit = close_rule();
           if (ctl_wr) begin m_link = ctl_link; m_close = ctl_close; end
           if (ctl_wr && !ctl_en) m_st = 2;
           else begin
             if (ep_req) begin m_xfer = 1; if (m_cnt == 1) fin = 1; m_cnt--; end
             if (hit) fin = 1;
           end
         end
      2: begin
           if (ctl_wr) begin m_link = ctl_link; m_close = ctl_close; end
           if (fifo_empty) begin m_en = 0; m_st = 0; end
         end
      default: if (desc_ack) begin
           m_en = desc_en; m_link = desc_link; m_close = desc_close;
           m_cnt = desc_len; m_st = 0;
         end
    endcase
    if (fin) begin m_eob = 1; m_en = 0; m_st = m_link ? 3 : 0; end
    m_act = (m_st != 0);
  endtask

  task automatic compare();
    check(sts_en == m_en, "R2", "sts_en", sts_en, m_en);
    check(xfer_strobe == m_xfer, "R3", "xfer_strobe", xfer_strobe, m_xfer);
    check(eob == m_eob, "R12", "eob", eob, m_eob);
    check(desc_req == (m_st == 3), "R10", "desc_req", desc_req, m_st == 3);
    check(sts_active == m_act, "R7", "sts_active", sts_active, m_act);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cycles++;
    if (!rst) compare();
    n_xfer += xfer_strobe; n_eob += eob; n_dreq += desc_req;
  endtask

  task automatic quiet();
    ctl_wr = 0; ep_req = 0; pkt_end = 0; pkt_short = 0; pid_mdata = 0;
    desc_ack = 0; fifo_empty = 1;
  endtask

  task automatic write(input bit e, input bit l, input bit c, input int len);
    ctl_wr = 1; ctl_en = e; ctl_link = l; ctl_close = c; ctl_len = LW'(len);
    tick();
    ctl_wr = 0;
  endtask

  task automatic clr();
    n_xfer = 0; n_eob = 0; n_dreq = 0;
  endtask

  task automatic finish_run();
    if (done_flag) return;
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1600000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 200000);
    finish_run();
  end

  initial begin
    quiet();
    @(negedge clk);
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    check({sts_en, sts_active, xfer_strobe, desc_req, eob} == 5'b0, "R1",
          "outputs after reset", {sts_en, sts_active, xfer_strobe, desc_req, eob}, 0);

    // R2: second write while enabled keeps length 2
    write(1, 0, 0, 2);
    check(sts_en == 1, "R2", "enable after write", sts_en, 1);
    write(1, 0, 0, 9);
    clr(); ep_req = 1;
    repeat (6) tick();
    ep_req = 0;
    check(n_xfer == 2, "R2", "strobes with kept length", n_xfer, 2);
    // R3 buffer completion
    check(n_eob == 1 && !sts_en && !sts_active, "R3", "eob count, idle after end",
          n_eob, 1);

    // R11 zero length
    write(1, 0, 0, 0);
    clr(); ep_req = 1; tick(); tick(); ep_req = 0;
    check(n_eob == 1 && n_xfer == 0, "R11", "eob without strobe", n_eob * 10 + n_xfer, 10);

    // R6 stop command
    write(0, 0, 0, 5);
    clr(); ep_req = 1; repeat (5) tick(); ep_req = 0;
    check(n_xfer == 0 && n_dreq == 0 && !sts_active, "R6", "stopped channel activity",
          n_xfer + n_dreq, 0);

    // R5 skip descriptor
    write(0, 1, 0, 5);
    clr(); ep_req = 1; tick(); tick(); ep_req = 0;
    check(desc_req && n_xfer == 0 && n_eob == 0, "R5", "skip raises desc_req only",
          desc_req, 1);
    // R10 hold, then load an enabled descriptor of length 2
    repeat (3) tick();
    check(desc_req == 1, "R10", "desc_req held", desc_req, 1);
    desc_ack = 1; desc_en = 1; desc_link = 0; desc_close = 0; desc_len = 2;
    tick(); desc_ack = 0;
    check(!desc_req && sts_en, "R10", "descriptor loaded", sts_en, 1);
    clr(); ep_req = 1; repeat (5) tick(); ep_req = 0;
    check(n_xfer == 2, "R10", "strobes from loaded length", n_xfer, 2);

    // R4 chain at end of buffer
    write(1, 1, 0, 1);
    clr(); ep_req = 1; tick(); tick(); ep_req = 0;
    check(eob && desc_req, "R4", "eob with desc_req", {eob, desc_req}, 3);
    desc_ack = 1; desc_en = 0; desc_link = 0; desc_len = 3; tick(); desc_ack = 0;
    check(!sts_en && !sts_active, "R10", "loaded enable 0 waits", sts_en, 0);

    // R7 drain
    write(1, 0, 0, 10);
    ep_req = 1; tick(); tick();
    fifo_empty = 0; ctl_wr = 1; ctl_en = 0; tick(); ctl_wr = 0;
    clr(); repeat (3) tick();
    check(n_xfer == 0 && sts_en && sts_active, "R7", "draining holds status",
          {sts_en, sts_active}, 3);
    fifo_empty = 1; tick(); ep_req = 0;
    check(!sts_en && !sts_active && n_eob == 0, "R7", "cleared after drain",
          {sts_en, sts_active}, 0);

    // R8 short packet close
    write(1, 0, 0, 12);
    ep_req = 1; tick(); ep_req = 0;
    clr(); pkt_end = 1; pkt_short = 1; tick(); tick();
    check(n_eob == 0 && sts_en, "R8", "short ignored without close", n_eob, 0);
    pkt_end = 0; ctl_wr = 1; ctl_en = 1; ctl_close = 1; tick(); ctl_wr = 0;
    pkt_end = 1; tick(); pkt_end = 0; pkt_short = 0;
    check(eob && !sts_en, "R8", "short closes buffer", eob, 1);

    // R9 isochronous PID close
    ep_hs_iso = 1;
    write(1, 0, 1, 12);
    ep_req = 1; tick(); ep_req = 0;
    clr(); pkt_end = 1; pid_mdata = 1; pkt_short = 1; tick(); tick();
    check(n_eob == 0 && sts_en, "R9", "MDATA keeps buffer open", n_eob, 0);
    pid_mdata = 0; pkt_short = 0; tick(); pkt_end = 0;
    check(eob && !sts_en, "R9", "non-MDATA closes buffer", eob, 1);
    ep_hs_iso = 0;
    tick();

    // random phase against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4000; i++) begin
      ctl_wr     = ($urandom % 10) == 0;
      ctl_en     = $urandom; ctl_link = $urandom; ctl_close = $urandom;
      ctl_len    = LW'($urandom);
      ep_req     = ($urandom % 3) != 0;
      ep_hs_iso  = ($urandom % 4) == 0;
      pkt_end    = ($urandom % 6) == 0;
      pkt_short  = $urandom; pid_mdata = $urandom;
      fifo_empty = ($urandom % 3) == 0;
      desc_ack   = ($urandom % 3) == 0;
      desc_en    = $urandom; desc_link = $urandom; desc_close = $urandom;
      desc_len   = LW'($urandom);
      tick();
    end
    quiet();
    tick();
    finish_run();
  end

endmodule